// File: doc/BRIEF.md
# Write-Invalidate Snooping Cache Controller

This block keeps one processor's small direct-mapped write-back cache coherent with the other caches on a shared snooping bus. Every line holds a tag, one data word and one of three states: Invalid (no data), Shared (readable, clean, equal to memory) and Exclusive (the only copy, writable and always dirty). Processor reads and writes arrive on a request/ready port that stalls the processor while a bus transaction is in flight. The block has one outstanding transaction at a time. It issues read misses, write misses and write-backs as bus master.

Transactions from the other caches arrive on a snoop port in bus order. A snooped read miss to an Exclusive line makes this cache supply the word, which also tells memory to abort its own answer and to capture the word. The line then drops to Shared. A snooped write miss invalidates any local copy. If that copy was Exclusive, its data is supplied on the bus first. A write hit on a Shared line is handled as a write miss, so a line only becomes Exclusive once a write miss has been on the bus.

Command encoding on both the master and the snoop side: 1 = read miss, 2 = write miss, 3 = write-back, 0 = none. An address splits into a low set index and a high tag.

Top module: `coh_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, and cpuReady, busReqValid and snpSupply are low. A snoop to any address does not supply data.
- R2: A CPU read that hits a Shared or Exclusive line raises cpuReady in the same cycle, returns the line's word on cpuRdata, and issues no bus transaction.
- R3: A CPU read miss issues a read miss (cmd 1) for the requested address. cpuReady and cpuRdata = busRespData appear in the cycle busAck is high. The line becomes Shared with the new tag.
- R4: A CPU write that hits an Exclusive line completes in the same cycle with no bus transaction, and updates the word.
- R5: A CPU write that hits a Shared line, or misses, issues a write miss (cmd 2). Only at its busAck does the line become Exclusive, holding the written word.
- R6: A CPU miss whose victim line is Exclusive first issues a write-back (cmd 3) with the victim's address and word, then issues the miss. A Shared or Invalid victim causes no write-back.
- R7: A snooped read miss (cmd 1) that hits an Exclusive line raises snpSupply with the word on snpData in the same cycle. The line becomes Shared.
- R8: A snooped write miss (cmd 2) that hits a Shared or Exclusive line makes the line Invalid. If the line was Exclusive, snpSupply and snpData carry its word in that same cycle.
- R9: A snoop that misses the tag, hits an Invalid line, or carries a write-back (cmd 3) does not supply data and leaves the line unchanged.
- R10: Once busReqValid is raised for a miss, it stays high with the same command and address until busAck.
- R11: If a snoop takes away an Exclusive victim while its write-back is still waiting for busAck, the write-back is withdrawn and the miss is issued without it.
- R12: Two addresses with different tags in the same set replace each other, and the state follows the newest tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | CPU request, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | CPU address |
| cpuWdata | input | DATA_W | CPU write word |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read word, valid with cpuReady |
| busReqValid | output | 1 | Master transaction request |
| busReqCmd | output | 2 | Master command (1 read miss, 2 write miss, 3 write-back) |
| busReqAddr | output | ADDR_W | Master address |
| busReqData | output | DATA_W | Write-back word |
| busAck | input | 1 | Transaction completes this cycle |
| busRespData | input | DATA_W | Fill word, valid with busAck |
| snpValid | input | 1 | Snooped transaction present |
| snpCmd | input | 2 | Snooped command |
| snpAddr | input | ADDR_W | Snooped address |
| snpSupply | output | 1 | This cache supplies the word, and memory aborts and captures it |
| snpData | output | DATA_W | Supplied word |

## Verification
CPU hits, supply decisions for snoops, and the ready/data answer to a final busAck are all combinational, so they are due in the same cycle as the stimulus. A miss raises busReqValid one clock after cpuReq is seen. State changes appear at the next clock edge. The bench drives inputs on the falling edge and samples a few nanoseconds later, still within that cycle. It counts clocks only while busReqValid is high, to decide when to return busAck. Line state is not read directly. It is inferred from the transactions and supply behaviour of later operations, and a reference model of tags, states and memory predicts them.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHR = 2'd1, LS_EXC = 2'd2} lineState_t;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RDMISS = 2'd1, BC_WRMISS = 2'd2, BC_WRBACK = 2'd3} busCmd_t;
  // control -> datapath strobes
  typedef struct packed {
    logic wrHit;      // write word into an Exclusive hit line
    logic dropVictim; // victim written back, mark Invalid
    logic fill;       // miss completed, install tag/word/state
    logic fillExc;    // fill as Exclusive with the CPU word
  } ctlStrobe_t;
endpackage

// File: rtl/coh_datapath.sv
`timescale 1ns/1ps
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              cpuHit,
  output logic              cpuLineExc,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] lineData,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              snpSameSet,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t        stateQ [SETS];
  logic [TAG_W-1:0]  tagQ   [SETS];
  logic [DATA_W-1:0] dataQ  [SETS];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             snpHit, snpRd, snpWr;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  assign cpuHit      = (stateQ[cpuIdx] != LS_INV) && (tagQ[cpuIdx] == cpuTag);
  assign cpuLineExc  = (stateQ[cpuIdx] == LS_EXC);
  assign victimDirty = cpuLineExc && (tagQ[cpuIdx] != cpuTag);
  assign victimAddr  = {tagQ[cpuIdx], cpuIdx};
  assign lineData    = dataQ[cpuIdx];
  assign cpuRdata    = ctl.fill ? busRespData : dataQ[cpuIdx];

  assign snpRd      = (snpCmd == BC_RDMISS);
  assign snpWr      = (snpCmd == BC_WRMISS);
  assign snpHit     = snpValid && (stateQ[snpIdx] != LS_INV) && (tagQ[snpIdx] == snpTag);
  assign snpSupply  = snpHit && (stateQ[snpIdx] == LS_EXC) && (snpRd || snpWr);
  assign snpData    = snpSupply ? dataQ[snpIdx] : '0;
  assign snpSameSet = snpValid && (snpIdx == cpuIdx);

  always_ff @(posedge clk) begin
    for (int i = 0; i < SETS; i++) begin
      if (rst) begin
        stateQ[i] <= LS_INV;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end else if (ctl.fill && cpuIdx == IDX_W'(i)) begin
        tagQ[i]   <= cpuTag;
        dataQ[i]  <= ctl.fillExc ? cpuWdata : busRespData;
        stateQ[i] <= ctl.fillExc ? LS_EXC : LS_SHR;
      end else begin
        if (ctl.dropVictim && cpuIdx == IDX_W'(i))
          stateQ[i] <= LS_INV;
        else if (snpHit && snpIdx == IDX_W'(i)) begin
          if (snpWr)
            stateQ[i] <= LS_INV;
          else if (snpRd && stateQ[i] == LS_EXC)
            stateQ[i] <= LS_SHR;
        end
        if (ctl.wrHit && cpuIdx == IDX_W'(i))
          dataQ[i] <= cpuWdata;
      end
    end
  end

  AST_SNP_RD_DOWNGRADE: assert property (@(posedge clk) disable iff (rst)
    (snpSupply && snpRd && !(ctl.fill && cpuIdx == snpIdx)) |=> stateQ[$past(snpIdx)] == LS_SHR); // R7
  AST_SNP_WR_INVAL: assert property (@(posedge clk) disable iff (rst)
    (snpHit && snpWr && !(ctl.fill && cpuIdx == snpIdx)) |=> stateQ[$past(snpIdx)] == LS_INV); // R8
  AST_SNP_WB_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (snpValid && snpCmd == BC_WRBACK && ctl == '0) |=> stateQ[$past(snpIdx)] == $past(stateQ[snpIdx])); // R9
endmodule

// File: rtl/coh_control.sv
`timescale 1ns/1ps
module coh_control
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuHit,
  input  logic              cpuLineExc,
  input  logic              victimDirty,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [DATA_W-1:0] lineData,
  input  logic              snpSameSet,
  input  logic              busAck,
  output logic              cpuReady,
  output ctlStrobe_t        ctl,
  output logic              busReqValid,
  output busCmd_t           busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData
);
  typedef enum logic [1:0] {CS_IDLE, CS_WB, CS_MISS} ctlState_t;
  ctlState_t stQ, stNxt;

  always_ff @(posedge clk) begin
    if (rst) stQ <= CS_IDLE;
    else     stQ <= stNxt;
  end

  always_comb begin
    stNxt       = stQ;
    ctl         = '0;
    cpuReady    = 1'b0;
    busReqValid = 1'b0;
    busReqCmd   = BC_NONE;
    busReqAddr  = cpuAddr;
    busReqData  = '0;
    unique case (stQ)
      CS_IDLE: begin
        if (cpuReq && !snpSameSet) begin
          if (cpuHit && (!cpuWrite || cpuLineExc)) begin
            cpuReady  = 1'b1;
            ctl.wrHit = cpuWrite;
          end else if (victimDirty) stNxt = CS_WB;
          else                      stNxt = CS_MISS;
        end
      end
      CS_WB: begin
        busReqCmd  = BC_WRBACK;
        busReqAddr = victimAddr;
        busReqData = lineData;
        if (!victimDirty) stNxt = CS_MISS;        // snoop took the victim
        else begin
          busReqValid = 1'b1;
          if (busAck) begin
            ctl.dropVictim = 1'b1;
            stNxt          = CS_MISS;
          end
        end
      end
      CS_MISS: begin
        busReqValid = 1'b1;
        busReqCmd   = cpuWrite ? BC_WRMISS : BC_RDMISS;
        if (busAck) begin
          ctl.fill    = 1'b1;
          ctl.fillExc = cpuWrite;
          cpuReady    = 1'b1;
          stNxt       = CS_IDLE;
        end
      end
      default: stNxt = CS_IDLE;
    endcase
  end

  AST_EXC_NEEDS_WRMISS: assert property (@(posedge clk) disable iff (rst)
    ctl.fillExc |-> (busReqValid && busReqCmd == BC_WRMISS && busAck)); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (busReqValid && !busAck && busReqCmd != BC_WRBACK) |=>
      (busReqValid && $stable(busReqAddr) && $stable(busReqCmd))); // R10
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (cpuReady && !ctl.fill) |-> !busReqValid); // R2
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (busReqValid && busReqCmd == BC_WRBACK) |-> (cpuLineExc && !cpuHit)); // R6
endmodule

// File: rtl/coh_snoop_cache.sv
`timescale 1ns/1ps
module coh_snoop_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRespData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);
  ctlStrobe_t        ctl;
  busCmd_t           cmdInt;
  logic              cpuHit, cpuLineExc, victimDirty, snpSameSet;
  logic [ADDR_W-1:0] victimAddr;
  logic [DATA_W-1:0] lineData;

  assign busReqCmd = cmdInt;

  coh_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuHit(cpuHit), .cpuLineExc(cpuLineExc), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .lineData(lineData), .snpSameSet(snpSameSet),
    .busAck(busAck), .cpuReady(cpuReady), .ctl(ctl), .busReqValid(busReqValid),
    .busReqCmd(cmdInt), .busReqAddr(busReqAddr), .busReqData(busReqData)
  );

  coh_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busRespData(busRespData), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .cpuHit(cpuHit), .cpuLineExc(cpuLineExc), .victimDirty(victimDirty),
    .victimAddr(victimAddr), .lineData(lineData), .cpuRdata(cpuRdata),
    .snpSameSet(snpSameSet), .snpSupply(snpSupply), .snpData(snpData)
  );
endmodule

// File: tb/test_coh_snoop_cache.sv
`timescale 1ns/1ps
module test_coh_snoop_cache;
  localparam int AW = 8, DW = 16, IW = 2, SETS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cpuReq = 0, cpuWrite = 0, busAck = 0, snpValid = 0;
  logic [AW-1:0] cpuAddr = '0, snpAddr = '0;
  logic [DW-1:0] cpuWdata = '0, busRespData = '0;
  logic [1:0] snpCmd = '0;
  logic cpuReady, busReqValid, snpSupply;
  logic [DW-1:0] cpuRdata, busReqData, snpData;
  logic [1:0] busReqCmd;
  logic [AW-1:0] busReqAddr;

  always #10 clk = ~clk;

  coh_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) i_coh_snoop_cache (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd), .busReqAddr(busReqAddr),
    .busReqData(busReqData), .busAck(busAck), .busRespData(busRespData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSupply(snpSupply), .snpData(snpData)
  );

  int nVec = 0, nBad = 0;
  bit finished = 0;
  logic [DW-1:0] mem [256];
  int            mState [SETS];   // 0 inv, 1 shared, 2 exclusive
  logic [5:0]    mTag   [SETS];
  logic [DW-1:0] mData  [SETS];

  task automatic chk(input string req, input longint act, input longint exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepCycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic snoopOp(input logic [1:0] cmd, input logic [AW-1:0] addr, input string force_lab);
    int idx = int'(addr[1:0]);
    bit hitM = (mState[idx] != 0) && (mTag[idx] == addr[7:2]);
    bit expSup = hitM && (mState[idx] == 2) && (cmd == 2'd1 || cmd == 2'd2);
    string lab;
    if (force_lab != "") lab = force_lab;
    else if (cmd == 2'd3 || !hitM) lab = "R9";
    else if (cmd == 2'd1) lab = "R7";
    else lab = "R8";
    snpValid = 1; snpCmd = cmd; snpAddr = addr;
    #2;
    chk(lab, snpSupply, expSup);
    if (expSup) begin
      chk(lab, snpData, mData[idx]);
      mem[addr] = mData[idx];
    end
    if (hitM && cmd == 2'd1 && mState[idx] == 2) mState[idx] = 1;
    if (hitM && cmd == 2'd2) mState[idx] = 0;
    stepCycle();
    snpValid = 0;
  endtask

  task automatic cpuOp(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                       input int ackDelay, input bit steal);
    int idx = int'(addr[1:0]);
    bit hit = (mState[idx] != 0) && (mTag[idx] == addr[7:2]);
    bit vDirty = (mState[idx] == 2) && !hit;
    bit stealEff = steal && vDirty && (ackDelay >= 2);
    logic [AW-1:0] vAddr = {mTag[idx], addr[1:0]};
    int expN = 0, gotN = 0, waitCnt = 0;
    logic [1:0] expCmd [2], gotCmd [4];
    logic [AW-1:0] expAddr [2], gotAddr [4];
    logic [DW-1:0] expData [2], gotData [4];
    logic [DW-1:0] expRd, rd;
    bit done = 0, prevValid = 0, stolen = 0;
    logic [1:0] prevCmd = '0;
    logic [AW-1:0] prevAddr = '0;
    string lab;
    if (!wr && hit) lab = "R2";
    else if (wr && hit && mState[idx] == 2) lab = "R4";
    else if (stealEff) lab = "R11";
    else if (vDirty) lab = "R6";
    else if (!hit && mState[idx] != 0) lab = "R12";
    else if (!wr) lab = "R3";
    else lab = "R5";
    rd = '0;
    if (vDirty && !stealEff) begin
      expCmd[expN] = 2'd3; expAddr[expN] = vAddr; expData[expN] = mData[idx]; expN++;
    end
    if (!(hit && (!wr || mState[idx] == 2))) begin
      expCmd[expN] = wr ? 2'd2 : 2'd1; expAddr[expN] = addr; expData[expN] = '0; expN++;
    end
    expRd = hit ? mData[idx] : mem[addr];
    cpuReq = 1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      #2;
      if (busReqValid) begin
        if (prevValid) chk("R10", {busReqCmd, busReqAddr}, {prevCmd, prevAddr});
        if (stealEff && !stolen && busReqCmd == 2'd3 && waitCnt == 1) begin
          stolen = 1;
          snpValid = 1; snpCmd = 2'd2; snpAddr = busReqAddr;
          #1;
          chk("R11", snpSupply, 1);
          chk("R11", snpData, mData[idx]);
          mem[vAddr] = mData[idx];
          mState[idx] = 0;
          prevValid = 0; waitCnt = 0;
          stepCycle();
          snpValid = 0;
          continue;
        end
        if (waitCnt >= ackDelay) begin
          busAck = 1;
          busRespData = mem[busReqAddr];
          if (busReqCmd == 2'd3) mem[busReqAddr] = busReqData;
          if (gotN < 4) begin
            gotCmd[gotN] = busReqCmd; gotAddr[gotN] = busReqAddr; gotData[gotN] = busReqData;
          end
          gotN++;
          #1;
          if (cpuReady) begin done = 1; rd = cpuRdata; end
          prevValid = 0; waitCnt = 0;
        end else begin
          waitCnt++; prevValid = 1; prevCmd = busReqCmd; prevAddr = busReqAddr;
          #1;
          chk(lab, cpuReady, 0);
        end
      end else begin
        prevValid = 0;
        #1;
        if (cpuReady) begin done = 1; rd = cpuRdata; end
      end
      stepCycle();
      busAck = 0;
    end
    cpuReq = 0;
    chk(lab, done, 1);
    chk(lab, gotN, expN);
    for (int k = 0; k < expN && k < gotN; k++) begin
      chk(lab, gotCmd[k], expCmd[k]);
      chk(lab, gotAddr[k], expAddr[k]);
      if (expCmd[k] == 2'd3) chk(lab, gotData[k], expData[k]);
    end
    if (!wr) chk(lab, rd, expRd);
    if (wr) begin
      mState[idx] = 2; mTag[idx] = addr[7:2]; mData[idx] = wd;
    end else if (!hit) begin
      mState[idx] = 1; mTag[idx] = addr[7:2]; mData[idx] = mem[addr];
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = DW'(a * 3 + 1);
    for (int s = 0; s < SETS; s++) begin mState[s] = 0; mTag[s] = '0; mData[s] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    chk("R1", cpuReady, 0);
    chk("R1", busReqValid, 0);
    chk("R1", snpSupply, 0);
    @(negedge clk);
    for (int s = 0; s < SETS; s++) snoopOp(2'd1, AW'(s), "R1");

    // directed: A and B share set 1
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R3 read miss
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R2 shared hit
    cpuOp(1, 8'h05, 16'hA1A1, 1, 0);     // R5 write hit shared
    cpuOp(1, 8'h05, 16'hB2B2, 0, 0);     // R4 exclusive hit
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R2 exclusive hit
    snoopOp(2'd1, 8'h05, "");            // R7 supply, downgrade
    cpuOp(1, 8'h05, 16'hC3C3, 2, 0);     // R5 again
    cpuOp(0, 8'h09, 16'h0, 1, 0);        // R6 dirty victim
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R12 clean victim
    snoopOp(2'd2, 8'h05, "");            // R8 shared invalidate
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R3 after invalidate
    cpuOp(1, 8'h05, 16'hD4D4, 0, 0);     // R5
    snoopOp(2'd3, 8'h05, "");            // R9 write-back snoop ignored
    snoopOp(2'd1, 8'h0D, "");            // R9 tag miss
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R2 still exclusive
    snoopOp(2'd2, 8'h05, "");            // R8 exclusive: supply + invalidate
    cpuOp(1, 8'h05, 16'hE5E5, 0, 0);     // R5
    cpuOp(0, 8'h09, 16'h0, 3, 1);        // R11 victim stolen
    cpuOp(0, 8'h05, 16'h0, 0, 0);        // R12

    // sweep
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      int op;
      a = {6'((i * 5 + i / 7) % 3 + 1), 2'((i * 3) % 4)};
      op = (i * 7 + 1) % 5;
      case (op)
        0: cpuOp(0, a, 16'h0, i % 3, (i % 3 == 2) && (i % 4 == 0));
        1: cpuOp(1, a, DW'(i * 37 + 5), i % 3, (i % 3 == 2) && (i % 4 == 0));
        2: snoopOp(2'd1, a, "");
        3: snoopOp(2'd2, a, "");
        default: snoopOp(2'd3, a, "");
      endcase
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule